// File: doc/BRIEF.md
# Multichannel ADC Sample Tile Packer

The packer sits between a bank of up to eight sample converters and a results buffer in memory. On every conversion strobe it captures one 12-bit result from each channel. After eight conversion points it has a complete group, which it reorders and packs four results to a 64-bit word. The words go out as incrementing write bursts on a simple master port. Each beat carries an address, the data word, the length of its burst, a first-beat flag and a master ID that identifies the channel of the word's first result.

Three buffer organisations are supported. Interleaved mode stores the results point by point, walking the enabled channels from lowest to highest. The two tiled modes group 4 or 8 successive results of one channel together. Software supplies the channel enable mask, the mode, the buffer base address, the number of chirps per frame and a chirp-length code. The frame then repeats with no further intervention: the address returns to the base after each frame and a one-cycle pulse marks every frame end.

Control is a three-state machine. S_FILL waits for a captured group and moves to S_PACK when one is ready. S_PACK writes one word per cycle into a word queue. When a group's last word has been packed, S_PACK goes to S_BURST if a full burst is queued or the frame is ending, and returns to S_FILL otherwise. S_BURST issues one beat per cycle. When the burst ends, S_BURST stays in S_BURST for a frame-end remainder and returns to S_FILL in every other case. The mask must have at least one bit set. The configuration is held static outside reset. Conversion strobes are at least eight cycles apart.

Top module: `adc_tile_packer`

## Requirements
- R1: Each 16-bit slot carries the 12-bit result in bits [15:4] with bits [3:0] zero. Slot 0 (bits [15:0]) holds the earliest result of the word, and slot 3 holds the latest.
- R2: Mode code 2 (tile-8) writes one enabled channel at a time. For each channel, two consecutive words carry points 0-3 and then points 4-7 of the group, and the channels follow in ascending order. Mode code 3 behaves as tile-8.
- R3: Mode code 1 (tile-4) first writes one word per enabled channel in ascending channel order, holding points 0-3 of the group. A second pass in the same channel order follows, holding points 4-7.
- R4: Mode code 0 (interleaved) forms a result stream ordered by conversion point. Within each point the enabled channels appear in ascending order, and the stream fills consecutive slots and words.
- R5: Each burst's beats are issued in consecutive cycles, and wr_first is high on the first beat only. In the tiled modes wr_blen equals twice the number of enabled channels (8, 12 and 16 beats for 4, 6 and 8 channels). In interleaved mode wr_blen is 16, and a burst starts only once all its words are assembled.
- R6: In interleaved mode, words left over at the end of a frame are issued as one final shorter burst, and wr_blen gives its true length.
- R7: The master ID of a channel c is c for channels 0-3 and c+4 for channels 4-7, so six channels 0-5 carry IDs 0, 1, 2, 3, 8 and 9. A beat's ID is the ID of the channel in its slot 0.
- R8: The first beat of a frame is written at base_addr. Each later beat is 8 bytes above the previous one, and the address returns to base_addr after the frame's last beat.
- R9: frame_done is high for exactly the cycle of the last beat of each frame.
- R10: A frame holds chirp_cnt chirps, each of (chirp_len_code+1)×8 conversion points, giving chirp_cnt×(chirp_len_code+1)×2×(enabled channels) words.
- R11: After reset, wr_valid and frame_done are low, and no beat is issued before a full group has been captured.
- R12: Results on channels whose mask bit is zero never appear in any word and take no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Conversion strobe common to all channels |
| smp_data | input | NCH*RES_W | Channel results; channel c at bits [c*RES_W +: RES_W] |
| ch_mask | input | NCH | Channel enable mask |
| org_mode | input | 2 | 0 interleaved, 1 tile-4, 2 or 3 tile-8 |
| base_addr | input | AW | Results buffer base byte address |
| chirp_cnt | input | CNT_W | Chirps per frame (at least 1) |
| chirp_len_code | input | CNT_W | Points per chirp = (code+1)×8 |
| wr_valid | output | 1 | Write beat present |
| wr_first | output | 1 | First beat of a burst |
| wr_addr | output | AW | Byte address of the beat |
| wr_data | output | 64 | Packed word |
| wr_blen | output | 5 | Beats in the current burst |
| wr_mid | output | 4 | Master ID of the beat |
| frame_done | output | 1 | Last beat of a frame |

## Verification
The bench targets configurations where the interleaved word count is not a multiple of sixteen. If the frame-end remainder is mishandled, those words are lost or the next frame starts at the wrong address. A sparse channel mask exposes a rank-to-channel lookup that uses physical indices, because disabled channels' data would then leak into the words. Two back-to-back frames show whether the address wraps to the base and whether the capture counters carry on correctly across the frame boundary. Tile-4 and tile-8 runs on the same channels separate the two walk orders: swapping the inner and outer loops puts the right results in the wrong words.

// File: rtl/tpk_pkg.sv
`timescale 1ns/1ps
package tpk_pkg;
    localparam int TILE_PTS  = 8;
    localparam int SLOT_W    = 16;
    localparam int SLOTS     = 4;
    localparam int WORD_W    = SLOT_W * SLOTS;
    localparam int MID_W     = 4;
    localparam int MAX_BEATS = 16;

    localparam logic [1:0] ORG_INTL  = 2'd0;
    localparam logic [1:0] ORG_TILE4 = 2'd1;

    typedef enum logic [1:0] {S_FILL, S_PACK, S_BURST} pk_state_e;

    // channels 0-3 keep their number, channels 4-7 sit four IDs higher
    function automatic logic [MID_W-1:0] chan_mid(input logic [2:0] ch);
        return {ch[2], 1'b0, ch[1:0]};
    endfunction
endpackage

// File: rtl/tpk_capture.sv
`timescale 1ns/1ps
module tpk_capture
    import tpk_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int RES_W = 12,
    parameter int CNT_W = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   stb,
    input  logic [NCH*RES_W-1:0]                   din,
    input  logic [CNT_W-1:0]                       chirps,
    input  logic [CNT_W-1:0]                       len_code,
    output logic [TILE_PTS-1:0][NCH*RES_W-1:0]     snap,
    output logic                                   grp_done,
    output logic                                   grp_last
);
    localparam int PW = $clog2(TILE_PTS);

    logic [TILE_PTS-1:0][NCH*RES_W-1:0] store;
    logic [PW-1:0]    pt;
    logic [CNT_W-1:0] grp;
    logic [CNT_W-1:0] chp;

    wire at_end    = (pt == PW'(TILE_PTS - 1));
    wire grp_end   = (grp == len_code);
    wire chirp_end = (chp == chirps - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store    <= '0;
            snap     <= '0;
            pt       <= '0;
            grp      <= '0;
            chp      <= '0;
            grp_done <= 1'b0;
            grp_last <= 1'b0;
        end else begin
            grp_done <= 1'b0;
            if (stb) begin
                store[pt] <= din;
                pt        <= pt + 1'b1;
                if (at_end) begin
                    for (int p = 0; p < TILE_PTS; p++)
                        snap[p] <= (p == TILE_PTS - 1) ? din : store[p];
                    grp_done <= 1'b1;
                    grp_last <= grp_end && chirp_end;
                    if (grp_end) begin
                        grp <= '0;
                        chp <= chirp_end ? '0 : chp + 1'b1;
                    end else begin
                        grp <= grp + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tpk_order.sv
`timescale 1ns/1ps
module tpk_order
    import tpk_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int RES_W = 12,
    localparam int CHW  = $clog2(NCH),
    localparam int PW   = $clog2(TILE_PTS)
) (
    input  logic [TILE_PTS-1:0][NCH*RES_W-1:0] snap,
    input  logic [NCH-1:0]                     mask,
    input  logic [1:0]                         mode,
    input  logic [PW:0]                        pt,
    input  logic [CHW:0]                       rk,
    input  logic [CHW:0]                       nch,
    output logic [WORD_W-1:0]                  word,
    output logic [MID_W-1:0]                   mid,
    output logic [PW:0]                        pt_nx,
    output logic [CHW:0]                       rk_nx
);
    logic [CHW-1:0] r2c [NCH];
    wire is_intl  = (mode == ORG_INTL);
    wire is_tile4 = (mode == ORG_TILE4);

    // rank of an enabled channel -> physical channel number
    always_comb begin
        logic [CHW:0] k;
        k = '0;
        for (int c = 0; c < NCH; c++) r2c[c] = '0;
        for (int c = 0; c < NCH; c++) begin
            if (mask[c]) begin
                r2c[k[CHW-1:0]] = CHW'(c);
                k = k + 1'b1;
            end
        end
    end

    always_comb begin
        logic [PW:0]      p;
        logic [CHW:0]     r;
        logic [CHW-1:0]   ch;
        logic [PW-1:0]    src;
        logic [RES_W-1:0] res;
        p    = pt;
        r    = rk;
        word = '0;
        mid  = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (is_intl) begin
                ch  = r2c[r[CHW-1:0]];
                src = p[PW-1:0];
            end else begin
                ch  = r2c[rk[CHW-1:0]];
                src = pt[PW-1:0] + PW'(i);
            end
            res = snap[src][ch*RES_W +: RES_W];
            word[i*SLOT_W +: SLOT_W] = {res, {(SLOT_W-RES_W){1'b0}}};
            if (i == 0) mid = chan_mid(3'(ch));
            if (is_intl) begin
                if (r == nch - 1'b1) begin
                    r = '0;
                    p = p + 1'b1;
                end else begin
                    r = r + 1'b1;
                end
            end
        end
        if (is_intl) begin
            pt_nx = p;
            rk_nx = r;
        end else if (is_tile4) begin
            pt_nx = (rk == nch - 1'b1) ? (PW+1)'(4) : pt;
            rk_nx = (rk == nch - 1'b1) ? '0 : rk + 1'b1;
        end else begin
            pt_nx = (pt == (PW+1)'(4)) ? '0 : (PW+1)'(4);
            rk_nx = (pt == (PW+1)'(4)) ? rk + 1'b1 : rk;
        end
    end
endmodule

// File: rtl/tpk_queue.sv
`timescale 1ns/1ps
module tpk_queue #(
    parameter int W     = 68,
    parameter int DEPTH = 32,
    localparam int QW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [QW:0]  count
);
    logic [W-1:0]  mem [DEPTH];
    logic [QW-1:0] wp;
    logic [QW-1:0] rp;

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            count <= count + (QW+1)'(push) - (QW+1)'(pop);
        end
    end

    assign dout = mem[rp];
endmodule

// File: rtl/adc_tile_packer.sv
`timescale 1ns/1ps
module adc_tile_packer
    import tpk_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int RES_W  = 12,
    parameter int AW     = 32,
    parameter int CNT_W  = 8,
    parameter int QDEPTH = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_stb,
    input  logic [NCH*RES_W-1:0] smp_data,
    input  logic [NCH-1:0]       ch_mask,
    input  logic [1:0]           org_mode,
    input  logic [AW-1:0]        base_addr,
    input  logic [CNT_W-1:0]     chirp_cnt,
    input  logic [CNT_W-1:0]     chirp_len_code,
    output logic                 wr_valid,
    output logic                 wr_first,
    output logic [AW-1:0]        wr_addr,
    output logic [63:0]          wr_data,
    output logic [4:0]           wr_blen,
    output logic [3:0]           wr_mid,
    output logic                 frame_done
);
    localparam int CHW = $clog2(NCH);
    localparam int PW  = $clog2(TILE_PTS);
    localparam int QCW = $clog2(QDEPTH) + 1;
    localparam int BLW = $clog2(MAX_BEATS) + 1;
    localparam int GW  = CHW + 2;

    logic [TILE_PTS-1:0][NCH*RES_W-1:0] snap;
    logic grp_done, grp_last;
    logic [PW:0]  pt, pt_nx;
    logic [CHW:0] rk, rk_nx, nch;
    logic [WORD_W-1:0] pk_word;
    logic [MID_W-1:0]  pk_mid;
    logic [WORD_W+MID_W-1:0] q_dout;
    logic [QCW-1:0] q_cnt;
    pk_state_e st, st_nx;
    logic [BLW-1:0] blen_q, blen_nx, bcnt, mode_len;
    logic [GW-1:0]  gwords, wcnt;
    logic [AW-1:0]  off;
    logic rdy, frm_last;

    tpk_capture #(.NCH(NCH), .RES_W(RES_W), .CNT_W(CNT_W)) i_cap (
        .clk(clk), .rst_n(rst_n), .stb(smp_stb), .din(smp_data),
        .chirps(chirp_cnt), .len_code(chirp_len_code),
        .snap(snap), .grp_done(grp_done), .grp_last(grp_last)
    );

    tpk_order #(.NCH(NCH), .RES_W(RES_W)) i_ord (
        .snap(snap), .mask(ch_mask), .mode(org_mode), .pt(pt), .rk(rk),
        .nch(nch), .word(pk_word), .mid(pk_mid), .pt_nx(pt_nx), .rk_nx(rk_nx)
    );

    tpk_queue #(.W(WORD_W + MID_W), .DEPTH(QDEPTH)) i_q (
        .clk(clk), .rst_n(rst_n), .push(st == S_PACK), .pop(st == S_BURST),
        .din({pk_mid, pk_word}), .dout(q_dout), .count(q_cnt)
    );

    assign nch      = (CHW+1)'($countones(ch_mask));
    assign gwords   = {nch, 1'b0};
    assign mode_len = (org_mode == ORG_INTL) ? BLW'(MAX_BEATS) : BLW'(gwords);

    wire [QCW-1:0] cnt_after = q_cnt + 1'b1;
    wire [QCW-1:0] rem       = q_cnt - 1'b1;
    wire pack_end  = (st == S_PACK)  && (wcnt == gwords - 1'b1);
    wire burst_end = (st == S_BURST) && (bcnt == blen_q - 1'b1);
    wire frame_end = burst_end && frm_last && (rem == '0);

    function automatic logic [BLW-1:0] fit(input logic [QCW-1:0] n,
                                           input logic [BLW-1:0] lim);
        return (n >= QCW'(lim)) ? lim : BLW'(n);
    endfunction

    always_comb begin
        st_nx   = st;
        blen_nx = blen_q;
        unique case (st)
            S_FILL:  if (rdy) st_nx = S_PACK;
            S_PACK:  if (pack_end) begin
                         if (cnt_after >= QCW'(mode_len) || frm_last) begin
                             st_nx   = S_BURST;
                             blen_nx = fit(cnt_after, mode_len);
                         end else begin
                             st_nx = S_FILL;
                         end
                     end
            S_BURST: if (burst_end) begin
                         if (rem != '0 && (frm_last || rem >= QCW'(mode_len))) begin
                             st_nx   = S_BURST;
                             blen_nx = fit(rem, mode_len);
                         end else begin
                             st_nx = S_FILL;
                         end
                     end
            default: st_nx = S_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= S_FILL;
            blen_q   <= '0;
            rdy      <= 1'b0;
            frm_last <= 1'b0;
            pt       <= '0;
            rk       <= '0;
            wcnt     <= '0;
            bcnt     <= '0;
            off      <= '0;
        end else begin
            st     <= st_nx;
            blen_q <= blen_nx;
            if (st == S_FILL && rdy) begin
                rdy      <= 1'b0;
                frm_last <= grp_last;
                pt       <= '0;
                rk       <= '0;
                wcnt     <= '0;
            end
            if (grp_done) rdy <= 1'b1;
            if (st == S_PACK) begin
                pt   <= pt_nx;
                rk   <= rk_nx;
                wcnt <= wcnt + 1'b1;
            end
            if (st == S_BURST) begin
                bcnt <= burst_end ? '0 : bcnt + 1'b1;
                off  <= frame_end ? '0 : off + AW'(8);
            end
            if (frame_end) frm_last <= 1'b0;
        end
    end

    always_comb begin
        wr_valid   = (st == S_BURST);
        wr_first   = (st == S_BURST) && (bcnt == '0);
        wr_blen    = blen_q;
        wr_addr    = base_addr + off;
        wr_data    = q_dout[WORD_W-1:0];
        wr_mid     = q_dout[WORD_W +: MID_W];
        frame_done = frame_end;
    end
endmodule

// File: rtl/tpk_checker.sv
`timescale 1ns/1ps
module tpk_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          wr_first,
    input logic [AW-1:0] wr_addr,
    input logic [4:0]    wr_blen,
    input logic [3:0]    wr_mid,
    input logic          frame_done,
    input logic [AW-1:0] base_addr
);
    logic [4:0]    beat;
    logic [AW-1:0] prev_addr;
    logic          had_beat;
    logic          prev_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat      <= '0;
            prev_addr <= '0;
            had_beat  <= 1'b0;
            prev_done <= 1'b0;
        end else if (wr_valid) begin
            beat      <= wr_first ? 5'd1 : beat + 5'd1;
            prev_addr <= wr_addr;
            had_beat  <= 1'b1;
            prev_done <= frame_done;
        end
    end

    wire [4:0] seen = wr_first ? 5'd1 : beat + 5'd1;

    p_gapless_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && seen != wr_blen) |=> wr_valid);
    p_first_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> wr_first);
    p_blen_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_blen != 5'd0 && wr_blen <= 5'd16));
    p_mid_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !wr_mid[2]);
    p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && had_beat) |->
            (wr_addr == (prev_done ? base_addr : prev_addr + AW'(8))));
    p_addr_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !had_beat) |-> (wr_addr == base_addr));
    p_done_on_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> wr_valid);
endmodule

bind adc_tile_packer tpk_checker #(.AW(AW)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_first(wr_first),
    .wr_addr(wr_addr), .wr_blen(wr_blen), .wr_mid(wr_mid),
    .frame_done(frame_done), .base_addr(base_addr)
);

// File: tb/test_adc_tile_packer.sv
`timescale 1ns/1ps
module test_adc_tile_packer;
    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  mask;
        logic [7:0]  chirps;
        logic [7:0]  lcode;
        logic [15:0] words;   // expected words per frame (R10)
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 8'h3F, 8'd2, 8'd1, 16'd48},
        '{2'd1, 8'h0F, 8'd1, 8'd1, 16'd16},
        '{2'd0, 8'h3F, 8'd1, 8'd0, 16'd12},
        '{2'd0, 8'hFF, 8'd1, 8'd1, 16'd32},
        '{2'd2, 8'hA5, 8'd1, 8'd0, 16'd8},
        '{2'd0, 8'h81, 8'd2, 8'd1, 16'd16},
        '{2'd1, 8'hFF, 8'd1, 8'd0, 16'd16},
        '{2'd0, 8'h3F, 8'd2, 8'd1, 16'd48},
        '{2'd3, 8'h0F, 8'd1, 8'd0, 16'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_stb = 1'b0;
    logic [95:0] smp_data = '0;
    logic [7:0]  ch_mask = 8'h0F;
    logic [1:0]  org_mode = 2'd0;
    logic [31:0] base_addr = '0;
    logic [7:0]  chirp_cnt = 8'd1;
    logic [7:0]  chirp_len_code = '0;
    logic        wr_valid, wr_first, frame_done;
    logic [31:0] wr_addr;
    logic [63:0] wr_data;
    logic [4:0]  wr_blen;
    logic [3:0]  wr_mid;

    int checks = 0;
    int fails = 0;
    int beats = 0;
    int dones = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    vec_t cur;

    adc_tile_packer i_adc_tile_packer (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
        .ch_mask(ch_mask), .org_mode(org_mode), .base_addr(base_addr),
        .chirp_cnt(chirp_cnt), .chirp_len_code(chirp_len_code),
        .wr_valid(wr_valid), .wr_first(wr_first), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_blen(wr_blen), .wr_mid(wr_mid),
        .frame_done(frame_done)
    );

    always #2.5 clk = ~clk;

    function automatic logic [11:0] smp(input int ch, input int n);
        return 12'((ch * 300 + n * 7 + 5) % 4096);
    endfunction

    function automatic int nth_ch(input logic [7:0] m, input int r);
        int k = 0;
        for (int c = 0; c < 8; c++) begin
            if (m[c]) begin
                if (k == r) return c;
                k++;
            end
        end
        return 0;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // beat monitor: expected values from the index arithmetic of R1-R10
    always @(negedge clk) begin
        if (mon_on && wr_valid) begin
            int nn, w_fr, f, b, ppf, pos, st, len, pnt, rank, ch, k, g, w;
            logic [63:0] ed;
            logic [3:0]  emid;
            string dreq;
            nn   = $countones(cur.mask);
            w_fr = int'(cur.words);
            f    = beats / w_fr;
            b    = beats % w_fr;
            ppf  = int'(cur.chirps) * (int'(cur.lcode) + 1) * 8;
            ed   = '0;
            emid = '0;
            for (int i = 0; i < 4; i++) begin
                if (cur.mode == 2'd0) begin
                    k    = 4 * b + i;
                    pnt  = k / nn;
                    rank = k % nn;
                end else begin
                    g = b / (2 * nn);
                    w = b % (2 * nn);
                    if (cur.mode == 2'd1) begin
                        rank = w % nn;
                        pnt  = g * 8 + (w / nn) * 4 + i;
                    end else begin
                        rank = w / 2;
                        pnt  = g * 8 + (w % 2) * 4 + i;
                    end
                end
                ch = nth_ch(cur.mask, rank);
                ed[i*16 +: 16] = {smp(ch, f * ppf + pnt), 4'b0000};
                if (i == 0) emid = (ch < 4) ? 4'(ch) : 4'(ch + 4);
            end
            if (cur.mode == 2'd0) begin
                pos = b % 16;
                st  = b - pos;
                len = (st + 16 <= w_fr) ? 16 : w_fr - st;
            end else begin
                pos = b % (2 * nn);
                len = 2 * nn;
            end
            dreq = (cur.mode == 2'd0) ? "R4/R1/R12 data" :
                   (cur.mode == 2'd1) ? "R3/R1/R12 data" : "R2/R1/R12 data";
            check(wr_data == ed, dreq, wr_data, ed);
            check(wr_addr == base_addr + 32'(8 * b), "R8 address",
                  64'(wr_addr), 64'(base_addr + 32'(8 * b)));
            check(wr_mid == emid, "R7 master id", 64'(wr_mid), 64'(emid));
            check(wr_blen == 5'(len), (len < 16 && cur.mode == 2'd0) ? "R6 short burst" : "R5 burst length",
                  64'(wr_blen), 64'(len));
            check(wr_first == (pos == 0), "R5 first beat",
                  64'(wr_first), 64'(pos == 0));
            check(frame_done == (b == w_fr - 1), "R9 frame done",
                  64'(frame_done), 64'(b == w_fr - 1));
            if (frame_done) dones++;
            beats++;
        end
    end

    initial begin
        for (int v = 0; v < NV; v++) begin
            cur            = VEC[v];
            rst_n          = 1'b0;
            org_mode       = cur.mode;
            ch_mask        = cur.mask;
            chirp_cnt      = cur.chirps;
            chirp_len_code = cur.lcode;
            base_addr      = 32'h2000_0000 + 32'(v) * 32'h1000;
            repeat (3) @(negedge clk);
            check(!wr_valid && !frame_done, "R11 reset outputs",
                  64'({wr_valid, frame_done}), 64'd0);
            rst_n  = 1'b1;
            beats  = 0;
            dones  = 0;
            mon_on = 1'b1;
            // fewer than eight points: nothing may be written (R11)
            for (int n = 0; n < 7; n++) begin
                @(negedge clk);
                smp_stb = 1'b1;
                for (int c = 0; c < 8; c++) smp_data[c*12 +: 12] = smp(c, n);
                @(negedge clk);
                smp_stb = 1'b0;
                repeat (6) @(negedge clk);
            end
            check(beats == 0, "R11 no early beat", 64'(beats), 64'd0);
            for (int n = 7; n < 2 * int'(cur.chirps) * (int'(cur.lcode) + 1) * 8; n++) begin
                @(negedge clk);
                smp_stb = 1'b1;
                for (int c = 0; c < 8; c++) smp_data[c*12 +: 12] = smp(c, n);
                @(negedge clk);
                smp_stb = 1'b0;
                repeat (6) @(negedge clk);
            end
            repeat (120) @(negedge clk);
            check(beats == 2 * int'(cur.words), "R10 words per two frames",
                  64'(beats), 64'(2 * int'(cur.words)));
            check(dones == 2, "R9 frame pulses", 64'(dones), 64'd2);
            mon_on = 1'b0;
        end
        finish_run();
    end
endmodule